// File: doc/BRIEF.md
# Mode-Selected Arithmetic/Logic Unit

This block is a purely combinational arithmetic/logic unit of parameterised width. A four-bit operation code picks one of twelve functions. Its top bit is the mode. The next two bits shape the second operand, and the last bit is a carry-in.

In arithmetic mode, an operand-shaping stage replaces B with zero, B, the bitwise inverse of B, or all ones. A single ripple adder then sums A, the shaped operand and the carry-in. This gives transfer, increment, add, add-plus-one, add-inverse, subtract, decrement and a second form of transfer.

In logic mode, a bitwise unit computes AND, OR, XOR or the inverse of A. A final selector drives the result. Four status flags go with the result: carry, signed overflow, negative and zero. A surrounding datapath uses the block as its shared function unit and samples the outputs within the same cycle.

Top module: `modal_alu`

## Requirements
- R1: `op_code` is read as {mode, s1, s0, cin}, from bit 3 down to bit 0. mode=0 selects arithmetic and mode=1 selects logic.
- R2: In arithmetic mode the result is (A + Y + cin) mod 2^WIDTH. Y is 0 for s1s0=00, B for 01, ~B for 10 and all ones for 11.
- R3: Code 0000 gives the result A, and code 0001 gives A+1.
- R4: Code 0010 gives A+B, code 0011 gives A+B+1, code 0100 gives A+~B and code 0101 gives A-B.
- R5: Code 0110 gives A-1, and code 0111 gives A.
- R6: In arithmetic mode `c_flag` is the carry out of the most significant bit of A + Y + cin.
- R7: In arithmetic mode `v_flag` is 1 exactly when the two's-complement sum A + Y + cin does not fit in WIDTH bits.
- R8: In logic mode, s1s0 picks the function: 00 gives A AND B, 01 gives A OR B, 10 gives A XOR B and 11 gives NOT A.
- R9: In logic mode the cin bit (bit 0) has no effect on any output.
- R10: In logic mode `c_flag` and `v_flag` are both 0.
- R11: `n_flag` equals the most significant bit of the result, and `z_flag` is 1 exactly when the result is all zeros, in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH | First operand |
| b_in | input | WIDTH | Second operand, shaped in arithmetic mode |
| op_code | input | 4 | {mode, s1, s0, cin} |
| g_out | output | WIDTH | Result |
| c_flag | output | 1 | Carry out (arithmetic mode only) |
| v_flag | output | 1 | Signed overflow (arithmetic mode only) |
| n_flag | output | 1 | Result sign bit |
| z_flag | output | 1 | Result is zero |

## Verification
The bench drives the operands 0x7F, 0x80, 0xFF and 0x00 into every code. These inputs decide the boundary flags. A design that takes carry-in from the MSB stage instead of comparing the MSB carries would report a wrong V on 0x7F+1 and 0x80-1. A design with s1 and s0 swapped in the operand stage would return A-B-1 where A+B is expected. A design that lets cin leak into the logic path, or that passes the adder carry through in logic mode, shows up in the cin-toggle pairs. Those pairs compare all outputs for each logic function. Pseudo-random operands then cover all sixteen codes against a reference built from signed and unsigned integer arithmetic.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef struct packed {
    logic mode;
    logic s1;
    logic s0;
    logic cin;
  } op_code_t;

  typedef enum logic [1:0] {
    LG_AND = 2'b00,
    LG_OR  = 2'b01,
    LG_XOR = 2'b10,
    LG_NOT = 2'b11
  } logic_fn_t;

endpackage

// File: rtl/alu_operand_shaper.sv
module alu_operand_shaper #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] b_val,
  input  logic             s1,
  input  logic             s0,
  output logic [WIDTH-1:0] y_val
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign y_val[i] = (b_val[i] & s0) | (~b_val[i] & s1);
  end

endmodule

// File: rtl/alu_ripple_adder.sv
module alu_ripple_adder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] x_val,
  input  logic [WIDTH-1:0] y_val,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out,
  output logic             carry_into_msb
);

  logic [WIDTH:0] chain;

  assign chain[0] = carry_in;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    assign sum[i]     = x_val[i] ^ y_val[i] ^ chain[i];
    assign chain[i+1] = (x_val[i] & y_val[i]) | (chain[i] & (x_val[i] ^ y_val[i]));
  end

  assign carry_out      = chain[WIDTH];
  assign carry_into_msb = chain[WIDTH-1];

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]     a_val,
  input  logic [WIDTH-1:0]     b_val,
  input  alu_pkg::logic_fn_t   fn,
  output logic [WIDTH-1:0]     res
);

  import alu_pkg::*;

  always_comb begin
    unique case (fn)
      LG_AND:  res = a_val & b_val;
      LG_OR:   res = a_val | b_val;
      LG_XOR:  res = a_val ^ b_val;
      LG_NOT:  res = ~a_val;
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/modal_alu.sv
module modal_alu #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic [3:0]       op_code,
  output logic [WIDTH-1:0] g_out,
  output logic             c_flag,
  output logic             v_flag,
  output logic             n_flag,
  output logic             z_flag
);

  import alu_pkg::*;

  localparam int MSB = WIDTH - 1;

  op_code_t        op;
  logic [MSB:0]    y_val;
  logic [MSB:0]    arith_res;
  logic [MSB:0]    logic_res;
  logic            add_cout;
  logic            add_cmsb;
  logic_fn_t       lfn;

  assign op  = op_code_t'(op_code);
  assign lfn = logic_fn_t'({op.s1, op.s0});

  alu_operand_shaper #(.WIDTH(WIDTH)) u_shaper (
    .b_val (b_in),
    .s1    (op.s1),
    .s0    (op.s0),
    .y_val (y_val)
  );

  alu_ripple_adder #(.WIDTH(WIDTH)) u_adder (
    .x_val          (a_in),
    .y_val          (y_val),
    .carry_in       (op.cin),
    .sum            (arith_res),
    .carry_out      (add_cout),
    .carry_into_msb (add_cmsb)
  );

  alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
    .a_val (a_in),
    .b_val (b_in),
    .fn    (lfn),
    .res   (logic_res)
  );

  always_comb begin
    if (op.mode) begin
      g_out  = logic_res;
      c_flag = 1'b0;
      v_flag = 1'b0;
    end else begin
      g_out  = arith_res;
      c_flag = add_cout;
      v_flag = add_cout ^ add_cmsb;
    end
    n_flag = g_out[MSB];
    z_flag = ~|g_out;
  end

endmodule

// File: rtl/modal_alu_chk.sv
module modal_alu_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] b_in,
  input logic [3:0]       op_code,
  input logic [WIDTH-1:0] g_out,
  input logic             c_flag,
  input logic             v_flag,
  input logic             n_flag,
  input logic             z_flag
);

  logic [WIDTH-1:0] y_ref;
  logic [WIDTH:0]   wide_sum;
  logic             known;

  always_comb begin
    case (op_code[2:1])
      2'b00:   y_ref = '0;
      2'b01:   y_ref = b_in;
      2'b10:   y_ref = ~b_in;
      default: y_ref = '1;
    endcase
    wide_sum = {1'b0, a_in} + {1'b0, y_ref} + {{WIDTH{1'b0}}, op_code[0]};
    known = !$isunknown({a_in, b_in, op_code});
  end

  always_comb begin
    if (known) begin
      // R2 R6
      arith_sum_chk: assert (op_code[3] || ({c_flag, g_out} == wide_sum));
      // R3
      transfer_chk: assert (op_code != 4'b0000 || g_out == a_in);
      // R7
      overflow_chk: assert (op_code[3] ||
        (v_flag == ((a_in[WIDTH-1] == y_ref[WIDTH-1]) && (g_out[WIDTH-1] != a_in[WIDTH-1]))));
      // R10
      logic_flags_chk: assert (!op_code[3] || (!c_flag && !v_flag));
      // R8
      not_a_chk: assert (op_code[3:1] != 3'b111 || g_out == ~a_in);
      // R11
      sign_zero_chk: assert (n_flag == g_out[WIDTH-1] && z_flag == (g_out == '0));
    end
  end

endmodule

bind modal_alu modal_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .a_in    (a_in),
  .b_in    (b_in),
  .op_code (op_code),
  .g_out   (g_out),
  .c_flag  (c_flag),
  .v_flag  (v_flag),
  .n_flag  (n_flag),
  .z_flag  (z_flag)
);

// File: tb/modal_alu_bench.sv
module modal_alu_bench;

  localparam int W = 8;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] a_in, b_in, g_out;
  logic [3:0]   op_code;
  logic         c_flag, v_flag, n_flag, z_flag;

  int checks = 0;
  int fails  = 0;
  logic [31:0] seed = 32'h1234_5678;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  modal_alu #(.WIDTH(W)) u_modal_alu (
    .a_in(a_in), .b_in(b_in), .op_code(op_code), .g_out(g_out),
    .c_flag(c_flag), .v_flag(v_flag), .n_flag(n_flag), .z_flag(z_flag)
  );

  // Expected {v,c,n,z,g} from integer arithmetic, per the requirements.
  function automatic logic [W+3:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic [3:0] op);
    logic [W-1:0] g;
    logic c, v;
    int ua, ub, us, sa, sb, ss, cin;
    ua = int'(a); ub = int'(b);
    sa = int'($signed(a)); sb = int'($signed(b));
    cin = int'(op[0]);
    c = 1'b0; v = 1'b0;
    if (!op[3]) begin
      case (op[2:1])
        2'b00: begin us = ua + cin;               ss = sa + cin; end
        2'b01: begin us = ua + ub + cin;          ss = sa + sb + cin; end
        2'b10: begin us = ua + (255 - ub) + cin;  ss = sa + (-sb - 1) + cin; end
        default: begin us = ua + 255 + cin;       ss = sa - 1 + cin; end
      endcase
      g = us[W-1:0];
      c = (us > 255);
      v = (ss > 127) || (ss < -128);
    end else begin
      case (op[2:1])
        2'b00: g = a & b;
        2'b01: g = a | b;
        2'b10: g = a ^ b;
        default: g = ~a;
      endcase
    end
    return {v, c, g[W-1], (g == '0), g};
  endfunction

  task automatic check(input string req, input logic [W+3:0] act, input logic [W+3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s a=%h b=%h op=%b actual vcnz/g=%b/%h expected vcnz/g=%b/%h",
               req, a_in, b_in, op_code, act[W+3:W], act[W-1:0], exp[W+3:W], exp[W-1:0]);
    end
  endtask

  function automatic logic [W+3:0] outs();
    return {v_flag, c_flag, n_flag, z_flag, g_out};
  endfunction

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic [3:0] op);
    @(negedge clk);
    a_in = a; b_in = b; op_code = op;
    #1;
  endtask

  task automatic t_reset_state();
    apply('0, '0, 4'b0000);
    // R11 R3: zero operands, transfer
    check("R11 reset", outs(), {4'b0001, 8'h00});
  endtask

  task automatic t_arith_named();
    apply(8'h35, 8'h12, 4'b0000); check("R3 transfer", outs(), {4'b0000, 8'h35});
    apply(8'h35, 8'h12, 4'b0001); check("R3 increment", outs(), {4'b0000, 8'h36});
    apply(8'h35, 8'h12, 4'b0010); check("R4 add", outs(), {4'b0000, 8'h47});
    apply(8'h35, 8'h12, 4'b0011); check("R4 add+1", outs(), {4'b0000, 8'h48});
    apply(8'h35, 8'h12, 4'b0100); check("R4 add inv", outs(), {4'b0100, 8'h22});
    apply(8'h35, 8'h12, 4'b0101); check("R4 subtract", outs(), {4'b0100, 8'h23});
    apply(8'h35, 8'h12, 4'b0110); check("R5 decrement", outs(), {4'b0100, 8'h34});
    apply(8'h35, 8'h12, 4'b0111); check("R5 transfer2", outs(), {4'b0100, 8'h35});
    // R1: the code 0010 is A+B only with bits read as {mode,s1,s0,cin}
    apply(8'h05, 8'h03, 4'b0010); check("R1 order", outs(), {4'b0000, 8'h08});
  endtask

  task automatic t_flag_corners();
    apply(8'h7F, 8'h00, 4'b0001); check("R7 pos overflow", outs(), {4'b1010, 8'h80});
    apply(8'h80, 8'h00, 4'b0110); check("R7 neg overflow", outs(), {4'b1100, 8'h7F});
    apply(8'hFF, 8'h00, 4'b0001); check("R6 carry wrap", outs(), {4'b0101, 8'h00});
    apply(8'h00, 8'h00, 4'b0110); check("R6 dec zero", outs(), {4'b0010, 8'hFF});
    apply(8'h80, 8'h80, 4'b0010); check("R7 add negs", outs(), {4'b1101, 8'h00});
    apply(8'h12, 8'h12, 4'b0101); check("R11 sub equal", outs(), {4'b0101, 8'h00});
  endtask

  task automatic t_logic_ops();
    apply(8'hC5, 8'h3C, 4'b1000); check("R8 and", outs(), {4'b0000, 8'h04});
    apply(8'hC5, 8'h3C, 4'b1010); check("R8 or",  outs(), {4'b0010, 8'hFD});
    apply(8'hC5, 8'h3C, 4'b1100); check("R8 xor", outs(), {4'b0010, 8'hF9});
    apply(8'hC5, 8'h3C, 4'b1110); check("R8 not", outs(), {4'b0000, 8'h3A});
    apply(8'hFF, 8'hFF, 4'b1110); check("R10 not zero", outs(), {4'b0001, 8'h00});
  endtask

  task automatic t_cin_ignored();
    for (int f = 0; f < 4; f++) begin
      logic [W+3:0] ref0;
      apply(8'hFF, 8'h81, {1'b1, f[1:0], 1'b0});
      ref0 = outs();
      apply(8'hFF, 8'h81, {1'b1, f[1:0], 1'b1});
      check("R9 cin ignored", outs(), ref0);
      check("R10 logic flags", {outs()[W+3:W+2], 2'b00, 8'h00}, 12'h000);
    end
  endtask

  task automatic t_sweep();
    logic [W-1:0] vals [4] = '{8'h00, 8'h7F, 8'h80, 8'hFF};
    for (int op = 0; op < 16; op++) begin
      for (int i = 0; i < 4; i++) begin
        for (int j = 0; j < 4; j++) begin
          apply(vals[i], vals[j], op[3:0]);
          check(op[3] ? "R8 sweep" : "R2 sweep", outs(), model(vals[i], vals[j], op[3:0]));
        end
      end
    end
    for (int k = 0; k < 400; k++) begin
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      apply(seed[7:0], seed[15:8], seed[19:16]);
      check(seed[19] ? "R8 random" : "R2 R6 R7 random", outs(),
            model(seed[7:0], seed[15:8], seed[19:16]));
    end
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    a_in = '0; b_in = '0; op_code = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_arith_named();
    t_flag_corners();
    t_logic_ops();
    t_cin_ignored();
    t_sweep();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule